// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-monitoring counter. Every clock it receives a flat vector of small per-cycle event counts, arranged as a number of event codes with eight sub-events each. A configuration word picks one event code and a unit mask. The counts of all sub-events whose mask bit is set are added together to form the cycle's event total.

The total then passes through a qualifier before it reaches the 48-bit accumulator. With a zero threshold the counter adds the raw total. With a nonzero threshold the counter adds one in each cycle that meets the threshold, or that falls below it when inversion is selected. An optional rising-edge detector turns this cycle count into an occurrence count. A 2-bit privilege level input gates counting against a kernel enable and a user enable.

Software can load the counter at any time. When the counter wraps, a sticky overflow bit is set. If the interrupt enable is set, the interrupt output is raised together with the overflow bit.

Top module: `perf_event_counter`

## Requirements
- R1: After a synchronous reset the counter reads 0, the overflow and interrupt outputs are low, the configuration is all zero (counting disabled), and the edge history is cleared.
- R2: The configuration word is 30 bits: event code [7:0], unit mask [15:8], user enable [16], kernel enable [17], edge [18], interrupt enable [19], counter enable [20], invert [21], threshold [29:22]. A word written in one cycle governs counting from the next cycle on.
- R3: With threshold 0 and the counter enabled, each cycle adds the sum of the selected code's sub-event counts whose unit-mask bit is set. Sub-event s of code c sits at bits [(c*8+s)*3 +: 3] of the event input. An event code with no inputs behind it (code 4 or above) contributes 0.
- R4: With a nonzero threshold and invert clear, the counter adds 1 in each cycle whose selected total is greater than or equal to the threshold, and adds 0 otherwise.
- R5: With a nonzero threshold and invert set, the counter adds 1 in each cycle whose total is below the threshold. With threshold 0, the invert and edge bits have no effect.
- R6: With edge set and a nonzero threshold, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle.
- R7: The kernel enable permits counting at privilege level 0. The user enable permits counting at levels 1, 2 and 3. When both enables are clear, all levels count.
- R8: A counter write loads the written value and clears the overflow bit, and it takes priority over an increment in the same cycle.
- R9: An increment that carries past all-ones sets the overflow bit, which then holds until a counter write. The interrupt output equals the overflow bit ANDed with the interrupt enable.
- R10: While the counter enable is clear the counter holds its value. Clearing the enable also clears the edge history, so a condition that is already true when counting is re-enabled counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_CODES*SUB_N*CNT_W | Per-cycle sub-event counts for all codes |
| cpl_i | input | 2 | Current privilege level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 30 | Configuration word |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_BITS | Counter load value |
| cnt_o | output | CNT_BITS | Counter value |
| ovf_o | output | 1 | Sticky overflow status |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The counter is cumulative, so a single wrong increment changes every later cnt_o value. This holds for a wrong mask sum, a misplaced compare, or an edge history that is not cleared, and the error appears at cnt_o one cycle after the faulty input cycle. A wrong overflow state appears on ovf_o and irq_o in the cycle after the wrapping increment. Because overflow is sticky, the wrong value then persists until a counter write, which keeps such an error visible for many cycles.

// File: rtl/pec_pkg.sv
`timescale 1ns/1ps
package pec_pkg;
  localparam int CFG_W = 30;

  // Configuration word, MSB first (30 bits)
  typedef struct packed {
    logic [7:0] thr;    // 29:22 per-cycle threshold
    logic       inv;    // 21    invert compare
    logic       en;     // 20    counter enable
    logic       ie;     // 19    interrupt enable
    logic       edg;    // 18    rising-edge mode
    logic       os;     // 17    kernel-level enable
    logic       usr;    // 16    user-level enable
    logic [7:0] umask;  // 15:8  sub-event mask
    logic [7:0] code;   // 7:0   event code
  } pec_cfg_t;
endpackage

// File: rtl/pec_select.sv
`timescale 1ns/1ps
module pec_select #(
  parameter int NUM_CODES = 4,
  parameter int SUB_N     = 8,
  parameter int CNT_W     = 3,
  parameter int SUM_W     = CNT_W + $clog2(SUB_N + 1)
) (
  input  logic [NUM_CODES*SUB_N*CNT_W-1:0] evt_i,
  input  logic [7:0]                       code_i,
  input  logic [SUB_N-1:0]                 umask_i,
  output logic [SUM_W-1:0]                 sum_o
);
  logic [SUM_W-1:0] code_sum [NUM_CODES];

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    always_comb begin
      code_sum[c] = '0;
      for (int s = 0; s < SUB_N; s++) begin
        if (umask_i[s])
          code_sum[c] = code_sum[c] + SUM_W'(evt_i[(c*SUB_N+s)*CNT_W +: CNT_W]);
      end
    end
  end

  always_comb begin
    sum_o = '0;
    for (int c = 0; c < NUM_CODES; c++) begin
      if (code_i == 8'(c)) sum_o = code_sum[c];
    end
  end
endmodule

// File: rtl/pec_qualify.sv
`timescale 1ns/1ps
module pec_qualify #(
  parameter int SUM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [1:0]       cpl_i,
  input  logic [7:0]       thr_i,
  input  logic             inv_i,
  input  logic             edg_i,
  input  logic             os_i,
  input  logic             usr_i,
  input  logic             en_i,
  output logic [SUM_W-1:0] inc_o
);
  localparam int CW = (SUM_W > 8) ? SUM_W : 8;

  logic           prev_q;
  logic           both, priv_ok, cmp, cond, qual;
  logic [CW-1:0]  sum_x, thr_x;

  assign sum_x   = CW'(sum_i);
  assign thr_x   = CW'(thr_i);
  assign both    = !os_i && !usr_i;
  assign priv_ok = (cpl_i == 2'd0) ? (os_i || both) : (usr_i || both);
  assign cmp     = inv_i ? (sum_x < thr_x) : (sum_x >= thr_x);
  assign cond    = (thr_i == 8'd0) ? (sum_i != '0) : cmp;
  assign qual    = cond && priv_ok;

  always_comb begin
    if (!en_i)                inc_o = '0;
    else if (thr_i == 8'd0)   inc_o = priv_ok ? sum_i : '0;
    else if (edg_i)           inc_o = SUM_W'(qual && !prev_q);
    else                      inc_o = SUM_W'(qual);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= en_i ? qual : 1'b0;
  end
endmodule

// File: rtl/pec_accum.sv
`timescale 1ns/1ps
module pec_accum #(
  parameter int CNT_BITS = 48,
  parameter int INC_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [INC_W-1:0]    inc_i,
  input  logic                we_i,
  input  logic [CNT_BITS-1:0] wdata_i,
  input  logic                ie_i,
  output logic [CNT_BITS-1:0] cnt_o,
  output logic                ovf_o,
  output logic                irq_o
);
  logic [CNT_BITS:0] nxt;
  logic              ovf_d;

  assign nxt   = {1'b0, cnt_o} + (CNT_BITS+1)'(inc_i);
  assign ovf_d = we_i ? 1'b0 : (ovf_o || nxt[CNT_BITS]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      cnt_o <= we_i ? wdata_i : nxt[CNT_BITS-1:0];
      ovf_o <= ovf_d;
      irq_o <= ovf_d && ie_i;
    end
  end
endmodule

// File: rtl/perf_event_counter.sv
`timescale 1ns/1ps
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int NUM_CODES = 4,
  parameter int SUB_N     = 8,
  parameter int CNT_W     = 3,
  parameter int CNT_BITS  = 48
) (
  input  logic                             clk_i,
  input  logic                             rst_i,
  input  logic [NUM_CODES*SUB_N*CNT_W-1:0] evt_i,
  input  logic [1:0]                       cpl_i,
  input  logic                             cfg_we_i,
  input  logic [CFG_W-1:0]                 cfg_wdata_i,
  input  logic                             cnt_we_i,
  input  logic [CNT_BITS-1:0]              cnt_wdata_i,
  output logic [CNT_BITS-1:0]              cnt_o,
  output logic                             ovf_o,
  output logic                             irq_o
);
  localparam int SUM_W = CNT_W + $clog2(SUB_N + 1);

  pec_cfg_t         cfg_q, cfg_d;
  logic [SUM_W-1:0] sum, inc;

  assign cfg_d = cfg_we_i ? pec_cfg_t'(cfg_wdata_i) : cfg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cfg_q <= '0;
    else       cfg_q <= cfg_d;
  end

  pec_select #(.NUM_CODES(NUM_CODES), .SUB_N(SUB_N), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_sel (
    .evt_i   (evt_i),
    .code_i  (cfg_q.code),
    .umask_i (cfg_q.umask[SUB_N-1:0]),
    .sum_o   (sum)
  );

  pec_qualify #(.SUM_W(SUM_W)) u_qual (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .sum_i (sum),
    .cpl_i (cpl_i),
    .thr_i (cfg_q.thr),
    .inv_i (cfg_q.inv),
    .edg_i (cfg_q.edg),
    .os_i  (cfg_q.os),
    .usr_i (cfg_q.usr),
    .en_i  (cfg_q.en),
    .inc_o (inc)
  );

  pec_accum #(.CNT_BITS(CNT_BITS), .INC_W(SUM_W)) u_acc (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .inc_i   (inc),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .ie_i    (cfg_d.ie),
    .cnt_o   (cnt_o),
    .ovf_o   (ovf_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/pec_chk.sv
`timescale 1ns/1ps
module pec_chk
  import pec_pkg::*;
#(
  parameter int CNT_BITS = 48
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic [1:0]          cpl_i,
  input logic                cnt_we_i,
  input logic [CNT_BITS-1:0] cnt_wdata_i,
  input logic [CNT_BITS-1:0] cnt_o,
  input logic                ovf_o,
  input logic                irq_o,
  input pec_cfg_t            cfg_q
);
  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i)) && !ovf_o);

  a_r9_irq_needs_ovf: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> ovf_o);

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (ovf_o && !cnt_we_i) |=> ovf_o);

  a_r10_disabled_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cfg_q.en && !cnt_we_i) |=> $stable(cnt_o));

  a_r7_kernel_blocked: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_q.en && !cnt_we_i && cpl_i == 2'd0 && cfg_q.usr && !cfg_q.os) |=> $stable(cnt_o));

  a_r4_single_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_q.en && cfg_q.thr != 8'd0 && !cnt_we_i && cnt_o != {CNT_BITS{1'b1}})
      |=> (cnt_o - $past(cnt_o)) <= CNT_BITS'(1));
endmodule

bind perf_event_counter pec_chk #(.CNT_BITS(CNT_BITS)) i_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .cpl_i       (cpl_i),
  .cnt_we_i    (cnt_we_i),
  .cnt_wdata_i (cnt_wdata_i),
  .cnt_o       (cnt_o),
  .ovf_o       (ovf_o),
  .irq_o       (irq_o),
  .cfg_q       (cfg_q)
);

// File: tb/test_perf_event_counter.sv
`timescale 1ns/1ps
module test_perf_event_counter;
  import pec_pkg::*;
  localparam int NC = 4, SN = 8, CW = 3, CB = 48;
  localparam int EVW = NC*SN*CW;

  logic clk = 1'b0, rst = 1'b1;
  logic [EVW-1:0] evt = '0;
  logic [1:0] cpl = '0;
  logic cfg_we = 1'b0, cnt_we = 1'b0;
  logic [CFG_W-1:0] cfg_wd = '0;
  logic [CB-1:0] cnt_wd = '0;
  logic [CB-1:0] cnt;
  logic ovf, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  pec_cfg_t m_cfg;
  logic [CB-1:0] m_cnt;
  logic m_ovf, m_irq, m_prev;

  always #2.5 clk = ~clk;

  perf_event_counter #(.NUM_CODES(NC), .SUB_N(SN), .CNT_W(CW), .CNT_BITS(CB)) i_perf_event_counter (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .cpl_i(cpl),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
    .cnt_o(cnt), .ovf_o(ovf), .irq_o(irq));

  function automatic pec_cfg_t mk(int code, int um, int thr, bit inv, bit edg,
                                  bit os, bit usr, bit ie, bit en);
    pec_cfg_t c;
    c.code = 8'(code); c.umask = 8'(um); c.thr = 8'(thr); c.inv = inv; c.edg = edg;
    c.os = os; c.usr = usr; c.ie = ie; c.en = en;
    return c;
  endfunction

  // one code's eight 3-bit sub-event counts placed in its slot
  function automatic logic [EVW-1:0] evfill(int code, logic [23:0] subs);
    logic [EVW-1:0] v = '0;
    v[code*24 +: 24] = subs;
    return v;
  endfunction

  function automatic int sel_sum(logic [EVW-1:0] ev, pec_cfg_t c);
    int s = 0;
    if (c.code < NC)
      for (int k = 0; k < SN; k++)
        if (c.umask[k]) s += int'(ev[(int'(c.code)*SN+k)*CW +: CW]);
    return s;
  endfunction

  task automatic step(input logic [EVW-1:0] ev, input logic [1:0] pl,
                      input bit cw, input pec_cfg_t cd,
                      input bit nw, input logic [CB-1:0] nd, input string tag);
    int sum, inc;
    bit both, pok, cond, q;
    logic [CB:0] t;
    @(negedge clk);
    evt = ev; cpl = pl; cfg_we = cw; cfg_wd = cd; cnt_we = nw; cnt_wd = nd;
    sum  = sel_sum(ev, m_cfg);
    both = !m_cfg.os && !m_cfg.usr;
    pok  = (pl == 0) ? (m_cfg.os || both) : (m_cfg.usr || both);
    cond = (m_cfg.thr == 0) ? (sum != 0) :
           (m_cfg.inv ? (sum < int'(m_cfg.thr)) : (sum >= int'(m_cfg.thr)));
    q    = cond && pok;
    if (!m_cfg.en)          inc = 0;
    else if (m_cfg.thr == 0) inc = pok ? sum : 0;
    else if (m_cfg.edg)     inc = (q && !m_prev) ? 1 : 0;
    else                    inc = q ? 1 : 0;
    m_prev = m_cfg.en ? q : 1'b0;
    if (nw) begin m_cnt = nd; m_ovf = 1'b0; end
    else begin
      t = {1'b0, m_cnt} + (CB+1)'(inc);
      m_cnt = t[CB-1:0];
      if (t[CB]) m_ovf = 1'b1;
    end
    if (cw) m_cfg = cd;
    m_irq = m_ovf && m_cfg.ie;
    @(posedge clk); #1;
    n_run++;
    if (cnt !== m_cnt || ovf !== m_ovf || irq !== m_irq) begin
      n_fail++;
      $display("FAIL %s: cnt=%0h exp %0h ovf=%0b exp %0b irq=%0b exp %0b",
               tag, cnt, m_cnt, ovf, m_ovf, irq, m_irq);
    end
  endtask

  task automatic expect_cnt(input logic [CB-1:0] v, input string tag);
    n_run++;
    if (cnt !== v) begin
      n_fail++;
      $display("FAIL %s: cnt=%0h exp %0h", tag, cnt, v);
    end
  endtask

  task automatic idle(input logic [EVW-1:0] ev, input logic [1:0] pl, input string tag);
    step(ev, pl, 1'b0, m_cfg, 1'b0, '0, tag);
  endtask

  localparam pec_cfg_t Z = '0;

  initial begin
    logic [EVW-1:0] busy;
    void'($urandom(32'd4711));
    m_cfg = '0; m_cnt = '0; m_ovf = 0; m_irq = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    n_run++;
    if (cnt !== '0 || ovf !== 1'b0 || irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: cnt=%0h ovf=%0b irq=%0b exp 0 0 0", cnt, ovf, irq);
    end
    idle(evfill(0, 24'hFFFFFF), 2'd0, "R1 disabled after reset");

    // R2/R3 raw sum with mask 0x05 on code 1: 3 + 4 = 7
    step('0, 2'd0, 1, mk(1, 8'h05, 0, 0, 0, 0, 0, 0, 1), 0, '0, "R2 cfg write");
    idle(evfill(1, {15'd0, 3'd4, 3'd7, 3'd3}), 2'd1, "R3 raw sum");
    expect_cnt(48'd7, "R3 masked sum 7");
    step(evfill(1, 24'hFFFFFF), 2'd0, 1, mk(9, 8'hFF, 0, 0, 0, 0, 0, 0, 1), 0, '0, "R2 new cfg next cycle");
    idle(evfill(1, 24'hFFFFFF), 2'd0, "R3 code out of range");
    idle(evfill(2, 24'hFFFFFF), 2'd0, "R3 code out of range");

    // R4 threshold 3 on code 0
    step('0, 2'd0, 1, mk(0, 8'hFF, 3, 0, 0, 0, 0, 0, 1), 1, '0, "R4 setup");
    idle(evfill(0, 24'd2), 2'd0, "R4 below thr");
    idle(evfill(0, 24'd3), 2'd0, "R4 equal thr");
    idle(evfill(0, 24'o77), 2'd0, "R4 above thr");
    expect_cnt(48'd2, "R4 two qualifying cycles");

    // R5 invert
    step('0, 2'd0, 1, mk(0, 8'hFF, 3, 1, 0, 0, 0, 0, 1), 1, '0, "R5 setup");
    idle(evfill(0, 24'd2), 2'd0, "R5 below thr");
    idle(evfill(0, 24'd3), 2'd0, "R5 equal thr");
    idle(evfill(0, 24'd0), 2'd0, "R5 zero");
    expect_cnt(48'd2, "R5 inverted count");
    step('0, 2'd0, 1, mk(0, 8'hFF, 0, 1, 1, 0, 0, 0, 1), 1, '0, "R5 thr0 setup");
    idle(evfill(0, 24'o5), 2'd0, "R5 inv ignored at thr0");
    idle(evfill(0, 24'o5), 2'd0, "R5 edge ignored at thr0");
    expect_cnt(48'd10, "R5 raw count despite inv and edge");

    // R6 edge with threshold 1
    busy = evfill(0, 24'd1);
    step('0, 2'd0, 1, mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 1), 1, '0, "R6 setup");
    repeat (4) idle(busy, 2'd0, "R6 busy");
    idle('0, 2'd0, "R6 idle");
    repeat (2) idle(busy, 2'd0, "R6 busy again");
    expect_cnt(48'd2, "R6 two occurrences");

    // R7 privilege gating
    step('0, 2'd0, 1, mk(0, 8'h01, 0, 0, 0, 1, 0, 0, 1), 1, '0, "R7 kernel only");
    idle(busy, 2'd0, "R7 kernel cpl0");
    idle(busy, 2'd2, "R7 kernel cpl2");
    expect_cnt(48'd1, "R7 kernel only counts cpl0");
    step('0, 2'd0, 1, mk(0, 8'h01, 0, 0, 0, 0, 1, 0, 1), 1, '0, "R7 user only");
    idle(busy, 2'd0, "R7 user cpl0");
    idle(busy, 2'd3, "R7 user cpl3");
    idle(busy, 2'd1, "R7 user cpl1");
    expect_cnt(48'd2, "R7 user counts cpl1..3 only");

    // R8 write priority
    step('0, 2'd0, 1, mk(0, 8'hFF, 0, 0, 0, 0, 0, 0, 1), 0, '0, "R8 setup");
    step(evfill(0, 24'hFFFFFF), 2'd0, 0, m_cfg, 1, 48'h123456789ABC, "R8 write wins");
    expect_cnt(48'h123456789ABC, "R8 written value");

    // R9 wrap and interrupt
    step('0, 2'd0, 1, mk(0, 8'h01, 0, 0, 0, 0, 0, 1, 1), 1, 48'hFFFF_FFFF_FFFE, "R9 setup");
    idle(evfill(0, 24'd3), 2'd0, "R9 wrap");
    expect_cnt(48'd1, "R9 wrapped value");
    idle('0, 2'd0, "R9 sticky");
    step('0, 2'd0, 1, mk(0, 8'h01, 0, 0, 0, 0, 0, 0, 1), 0, '0, "R9 irq follows enable");
    step('0, 2'd0, 0, m_cfg, 1, 48'd5, "R9 write clears");

    // R10 disable holds and clears edge history
    step('0, 2'd0, 1, mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 1), 1, '0, "R10 setup");
    repeat (2) idle(busy, 2'd0, "R10 busy");
    step(busy, 2'd0, 1, mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 0), 0, '0, "R10 disable");
    repeat (2) idle(busy, 2'd0, "R10 hold");
    step(busy, 2'd0, 1, mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 1), 0, '0, "R10 re-enable");
    idle(busy, 2'd0, "R10 recount");
    idle(busy, 2'd0, "R10 still busy");
    expect_cnt(48'd2, "R10 history cleared on disable");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [EVW-1:0] ev = {$urandom, $urandom, $urandom};
      bit cw = ($urandom % 20) == 0;
      bit nw = ($urandom % 30) == 0;
      pec_cfg_t c = mk($urandom % 5, $urandom, $urandom % 8, $urandom, $urandom,
                       $urandom, $urandom, $urandom, ($urandom % 8) != 0);
      logic [CB-1:0] d = ($urandom % 2) ? {16'hFFFF, 32'hFFFF_FFF0 | 32'($urandom % 16)}
                                        : {16'd0, 32'($urandom)};
      step(ev, 2'($urandom), cw, c, nw, d, "R3/R4/R5/R6/R7/R9 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule